// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Prescaler

This block derives a slow converter clock from the system clock. The high phase and the low phase of that clock are each set by their own field in a 16-bit control word. A third field, a single adjust bit, moves half a system clock cycle out of the low phase and into the high phase. The total period does not change, so odd half-cycle duty ratios are possible. Because of that half-cycle move, the output is assembled from a rising-edge phase counter and a falling-edge stretch flop.

Software writes the control word through a simple write strobe and can read it back at any time. The new timing is captured only at the start of a high phase, so a write never cuts a phase short. The control word also carries a select bit for external channel multiplexing. The block only stores that bit and drives it out; it takes no other action on it. Downstream sequencing logic gets a one-cycle strobe with every rising edge of the converter clock.

Top module: `pscl_top`

## Requirements
- R1: While reset is asserted and after it, the control word reads 16'h0033: high code 3 in bits 8..4, adjust bit 3 clear, low code 3 in bits 2..0, select bit 15 clear. During reset the converter clock and the strobe are low.
- R2: Bits 14..9 always read as zero, and writing them has no effect. Writing 16'hFFFF reads back as 16'h81FF on the cycle after the write.
- R3: With the adjust bit inactive, the high phase lasts N+1 system cycles, where N is the code in bits 8..4 (1 to 32 cycles).
- R4: With the adjust bit inactive, the low phase lasts M+1 system cycles, where M is the code in bits 2..0 (1 to 8 cycles).
- R5: With the adjust bit set and M nonzero, the high phase lasts N+1.5 cycles and the low phase M+0.5 cycles. The period stays unchanged.
- R6: With the adjust bit set and M equal to zero, the adjust bit is ignored and the timing follows R3 and R4.
- R7: A written value first takes effect at the next rising edge of the converter clock. The phase in progress, and the low phase that follows it, keep the values captured at the last rise. A write accepted on the same clock edge as a rise takes effect only at the following rise.
- R8: The strobe is high for exactly the one system cycle that begins with each rising edge of the converter clock.
- R9: The mux select output equals bit 15 of the stored control word.
- R10: The first rising edge of the converter clock comes at the first system clock rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Writes wr_data into the control word on the rising edge |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Stored control word, reserved bits zero |
| ext_mux_sel | output | 1 | External multiplexing select, bit 15 |
| conv_clk | output | 1 | Converter clock with the programmed duty cycle |
| conv_rise | output | 1 | One-cycle strobe at each rising edge of conv_clk |

## Verification
Two situations are the hardest to reach from the ports. The first is a write accepted on the exact edge where a new high phase begins, so that the capture must take the old value. The second is the adjust bit combined with a one-cycle low phase. The bench steps through every high code, low code and adjust setting one after the other, and it never waits for phase boundaries between writes. Each write therefore lands at a different point in the running waveform, and some land on the capture edge itself. A reference model that counts half cycles checks the clock level in both halves of every system cycle, so a half-cycle error shows up directly.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  localparam int CTRL_W  = 16;
  localparam int HI_W    = 5;
  localparam int LO_W    = 3;
  localparam int LO_LSB  = 0;
  localparam int ADJ_BIT = LO_LSB + LO_W;
  localparam int HI_LSB  = ADJ_BIT + 1;
  localparam int MUX_BIT = CTRL_W - 1;
  localparam int CNT_W   = (HI_W > LO_W) ? HI_W : LO_W;

  localparam logic [CTRL_W-1:0] CTRL_RST  = CTRL_W'(16'h0033);
  localparam logic [CTRL_W-1:0] CTRL_MASK =
      (CTRL_W'(1) << MUX_BIT) |
      (((CTRL_W'(1) << HI_W) - CTRL_W'(1)) << HI_LSB) |
      (CTRL_W'(1) << ADJ_BIT) |
      (((CTRL_W'(1) << LO_W) - CTRL_W'(1)) << LO_LSB);

  typedef struct packed {
    logic            mux;
    logic [HI_W-1:0] hi;
    logic            adj;
    logic [LO_W-1:0] lo;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] v);
    ctrl_t f;
    f.mux = v[MUX_BIT];
    f.hi  = v[HI_LSB +: HI_W];
    f.adj = v[ADJ_BIT];
    f.lo  = v[LO_LSB +: LO_W];
    return f;
  endfunction

  // The half-cycle shift needs a low phase of at least two cycles.
  function automatic logic adj_allowed(input logic adj, input logic [LO_W-1:0] lo);
    return adj && (lo != '0);
  endfunction

  // Down-counter reload values: a code C gives C+1 cycles.
  function automatic logic [CNT_W-1:0] hi_reload(input logic [HI_W-1:0] code);
    return CNT_W'(code);
  endfunction

  function automatic logic [CNT_W-1:0] lo_reload(input logic [LO_W-1:0] code);
    return CNT_W'(code);
  endfunction
endpackage

// File: rtl/pscl_ctrl_reg.sv
module pscl_ctrl_reg
  import pscl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output ctrl_t             fields
);
  logic [CTRL_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= CTRL_RST;
    else if (wr_en) word_q <= wr_data & CTRL_MASK;
  end

  assign rd_data = word_q;
  assign fields  = unpack_ctrl(word_q);

  // R2: a write shows up masked on the next cycle
  assert_write_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> rd_data == ($past(wr_data) & CTRL_MASK));
endmodule

// File: rtl/pscl_phase_gen.sv
module pscl_phase_gen
  import pscl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t fields,
  output logic  hi_pos,
  output logic  stretch_req,
  output logic  rise_stb
);
  logic             hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  cur_hi;
  logic [LO_W-1:0]  cur_lo;
  logic             cur_adj;
  logic             stb_q;

  logic phase_done;
  logic start_hi;
  assign phase_done = (cnt_q == '0);
  assign start_hi   = !hi_q && phase_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= 1'b0;
      cnt_q   <= '0;
      cur_hi  <= '0;
      cur_lo  <= '0;
      cur_adj <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= start_hi;
      if (phase_done) begin
        if (hi_q) begin
          hi_q  <= 1'b0;
          cnt_q <= lo_reload(cur_lo);
        end else begin
          hi_q    <= 1'b1;
          cnt_q   <= hi_reload(fields.hi);
          cur_hi  <= fields.hi;
          cur_lo  <= fields.lo;
          cur_adj <= adj_allowed(fields.adj, fields.lo);
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign hi_pos      = hi_q;
  assign rise_stb    = stb_q;
  assign stretch_req = hi_q && phase_done && cur_adj;

  assert_hi_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |-> cnt_q <= CNT_W'(cur_hi));
  assert_lo_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_q |-> cnt_q <= CNT_W'(cur_lo));
  assert_adj_needs_long_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_adj |-> cur_lo != '0);
  assert_snapshot_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_hi |=> $stable(cur_hi) && $stable(cur_lo) && $stable(cur_adj));
  assert_strobe_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> stb_q);
  assert_strobe_only_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> hi_q);
endmodule

// File: rtl/pscl_half_stretch.sv
module pscl_half_stretch (
  input  logic clk,
  input  logic rst_n,
  input  logic stretch_req,
  output logic ext_q
);
  // Set at mid-cycle of the last high cycle, so the extension overlaps
  // the high phase and releases at mid-cycle of the first low cycle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= stretch_req;
  end
endmodule

// File: rtl/pscl_top.sv
module pscl_top
  import pscl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              ext_mux_sel,
  output logic              conv_clk,
  output logic              conv_rise
);
  ctrl_t fields;
  logic  hi_pos;
  logic  stretch_req;
  logic  ext_q;

  pscl_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fields(fields)
  );

  pscl_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .fields(fields),
    .hi_pos(hi_pos), .stretch_req(stretch_req), .rise_stb(conv_rise)
  );

  pscl_half_stretch u_stretch (
    .clk(clk), .rst_n(rst_n), .stretch_req(stretch_req), .ext_q(ext_q)
  );

  assign conv_clk    = hi_pos | ext_q;
  assign ext_mux_sel = fields.mux;

  // R5: the stretch never reaches past the first low cycle
  assert_stretch_inside_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |-> hi_pos);
  // R10: the first system edge after reset starts a high phase
  assert_first_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> hi_pos);
endmodule

// File: tb/pscl_top_tb.sv
`timescale 1ns/1ps
module pscl_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        ext_mux_sel, conv_clk, conv_rise;

  pscl_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ext_mux_sel(ext_mux_sel),
    .conv_clk(conv_clk), .conv_rise(conv_rise)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  // behavioural reference, counted in half system cycles
  int          lvl, rem, lo_h_next;
  bit          rose;
  bit          per_adj, per_m0;
  logic [15:0] shadow;
  string       override_tag = "";

  function automatic int halves_high(logic [15:0] w);
    int n = w[8:4];
    int m = w[2:0];
    int a = (w[3] && m != 0) ? 1 : 0;
    return 2 * (n + 1) + a;
  endfunction

  function automatic int halves_low(logic [15:0] w);
    int m = w[2:0];
    int a = (w[3] && m != 0) ? 1 : 0;
    return 2 * (m + 1) - a;
  endfunction

  task automatic check(string tag, int actual, int expected, string what);
    vectors++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, actual, expected, $time);
    end
  endtask

  task automatic advance();
    rem--;
    if (rem == 0) begin
      if (lvl == 1) begin
        lvl = 0;
        rem = lo_h_next;
      end else begin
        lvl       = 1;
        rem       = halves_high(shadow);
        lo_h_next = halves_low(shadow);
        per_adj   = shadow[3];
        per_m0    = (shadow[2:0] == 3'd0);
        rose      = 1;
      end
    end
  endtask

  function automatic string wave_tag();
    if (override_tag != "") return override_tag;
    if (per_adj) return per_m0 ? "R6" : "R5";
    return (lvl == 1) ? "R3" : "R4";
  endfunction

  task automatic tick();
    @(posedge clk);
    rose = 0;
    advance();
    if (wr_en) shadow = wr_data & 16'h81FF;  // committed after any capture at this edge (R7)
    #2;
    check(wave_tag(), conv_clk, lvl, "conv_clk first half");
    check("R8", conv_rise, rose, "conv_rise");
    @(negedge clk);
    advance();
    #2;
    check(wave_tag(), conv_clk, lvl, "conv_clk second half");
    check("R8", conv_rise, rose, "conv_rise second half");
  endtask

  task automatic write_word(logic [15:0] v);
    wr_en   = 1'b1;
    wr_data = v;
    tick();
    wr_en   = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1", rd_data, 16'h0033, "rd_data in reset");
    check("R1", conv_clk, 0, "conv_clk in reset");
    check("R1", conv_rise, 0, "conv_rise in reset");
    check("R9", ext_mux_sel, 0, "mux in reset");
    rst_n = 1'b1;
    lvl = 0; rem = 1; lo_h_next = 2; shadow = 16'h0033;
    per_adj = 0; per_m0 = 0;
    // R10: the first tick expects a rise at the first edge
    tick();
    check("R10", conv_clk, 1, "first rise after reset");
    check("R1", rd_data, 16'h0033, "rd_data after reset");
    repeat (20) tick();

    // R2 and R9: reserved bits dropped, select bit stored
    write_word(16'hFFFF);
    check("R2", rd_data, 16'h81FF, "rd_data after all-ones");
    check("R9", ext_mux_sel, 1, "mux set");
    repeat (3) tick();
    write_word(16'h7E00);
    check("R2", rd_data, 16'h0000, "rd_data reserved only");
    check("R9", ext_mux_sel, 0, "mux clear");
    repeat (6) tick();

    // R7: long high phase, then a change written while it runs
    write_word(16'h01F7);
    while (conv_rise !== 1'b1) tick();
    override_tag = "R7";
    repeat (4) tick();
    write_word(16'h0000);
    repeat (80) tick();
    override_tag = "";

    // R3..R6 sweep; writes fall at arbitrary phase points, some on the capture edge (R7)
    for (int a = 0; a < 2; a++) begin
      for (int n = 0; n < 32; n++) begin
        for (int m = 0; m < 8; m++) begin
          write_word({1'b0, 6'b0, 5'(n), 1'(a), 3'(m)});
          repeat (2 * (n + m + 2) + 1) tick();
        end
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule